// File: doc/BRIEF.md
# Tag Check Failure Handler

This unit receives an event saying that an access failed its memory tag check. The event carries the faulting virtual address, a write flag and the exception level that is running. The unit picks the tag-check mode that applies to that level. Each level has its own 2-bit mode field. Level 0 takes its mode from one of two sources, chosen by a host-enable bit and a trap-general bit.

The chosen mode decides what the unit does. In fault mode it raises a synchronous fault request one cycle later. The request carries the target level, a fixed syndrome, the faulting address and a zero vector offset. In record mode it sets a sticky status flag instead. There is one flag per level and per translation-table half, and address bit 55 selects the half.

The flags stay set until software clears them with a masked clear strobe. The tag comparison itself is done elsewhere.

Top module: `tag_fail_unit`

## Requirements
- R1: After reset, `flt_valid` is 0 and all seven bits of `tf_flags` are 0.
- R2: At levels 3, 2 and 1 the effective mode is that level's own field (`mode_l3`, `mode_l2`, `mode_l1`).
- R3: At level 0 the effective mode is `mode_l0_host` when `host_en` and `trap_gen` are both 1, and `mode_l0_guest` otherwise.
- R4: An event (`ev_valid`=1) whose effective mode is 01 drives `flt_valid` high for exactly the next cycle, with `flt_addr` equal to the event address.
- R5: A fault raised at level 0 targets level 1 when `trap_gen` is 0 and level 2 when it is 1. A fault raised at any other level targets the current level.
- R6: The fault syndrome has bits [5:0] = 010001 and bit 6 = the write flag, with all higher bits 0. `flt_vec_off` is 0.
- R7: An event whose effective mode is 10 raises no fault and sets one flag. At levels 0 to 2 the flag index is 2*level + address bit 55, so bit 0 is L0/half0 and bit 5 is L2/half1.
- R8: A record event at level 3 sets flag bit 6 whatever the value of address bit 55, because level 3 has only one half.
- R9: Effective modes 00 and 11 cause no fault and leave the flags unchanged.
- R10: A flag stays set until a cycle with `clr_valid`=1 and the matching `clr_mask` bit set. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: With `ev_valid`=0 no fault is raised and no flag changes, whatever the mode fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Tag check failure event strobe |
| ev_addr | input | ADDR_W | Faulting virtual address |
| ev_write | input | 1 | Event is a write access |
| cur_lvl | input | 2 | Current exception level |
| mode_l3 | input | 2 | Mode field for level 3 |
| mode_l2 | input | 2 | Mode field for level 2 |
| mode_l1 | input | 2 | Mode field for level 1 |
| mode_l0_host | input | 2 | Level-0 mode field held in the level-2 control |
| mode_l0_guest | input | 2 | Level-0 mode field held in the level-1 control |
| host_en | input | 1 | Host-enable control bit |
| trap_gen | input | 1 | Trap-general control bit |
| clr_valid | input | 1 | Software clear strobe |
| clr_mask | input | 7 | Flags to clear |
| flt_valid | output | 1 | Fault request pulse |
| flt_lvl | output | 2 | Target level of the fault |
| flt_synd | output | SYND_W | Fault syndrome |
| flt_addr | output | ADDR_W | Reported faulting address |
| flt_vec_off | output | VEC_W | Vector offset |
| tf_flags | output | 7 | Sticky flags, bit 2*level+half, bit 6 = level 3 |

## Verification
The bench sweeps every level, every mode, both control bits, the write flag and address bit 55. In each case every mode field other than the selected one holds the bitwise complement of the tested mode. A design that reads the wrong level-0 source, or ANDs the control bits the wrong way, therefore faults where it should record, or records where it should fault. A design that lets bit 55 reach level 3 sets a non-existent bit 7 or the wrong flag. A design that routes a level-0 fault to the current level reports target 0.

Further cases cover the sticky flags. A masked clear must leave the unselected flags alone. A set and a clear of the same bit in one cycle must leave the bit set, and a design that gives the clear priority silently loses that event. An idle cycle with fault-mode fields must raise no pulse.

// File: rtl/tag_fail_unit.sv
module tag_fail_unit #(
  parameter int ADDR_W  = 64,
  parameter int TAG_BIT = 55,
  parameter int SYND_W  = 25,
  parameter int VEC_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_write,
  input  logic [1:0]        cur_lvl,
  input  logic [1:0]        mode_l3,
  input  logic [1:0]        mode_l2,
  input  logic [1:0]        mode_l1,
  input  logic [1:0]        mode_l0_host,
  input  logic [1:0]        mode_l0_guest,
  input  logic              host_en,
  input  logic              trap_gen,
  input  logic              clr_valid,
  input  logic [6:0]        clr_mask,
  output logic              flt_valid,
  output logic [1:0]        flt_lvl,
  output logic [SYND_W-1:0] flt_synd,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [VEC_W-1:0]  flt_vec_off,
  output logic [6:0]        tf_flags
);
  localparam logic [1:0] MODE_FAULT  = 2'b01;
  localparam logic [1:0] MODE_RECORD = 2'b10;
  localparam logic [5:0] SYND_CODE   = 6'b010001;

  logic [1:0]        eff_mode;
  logic              fire, rec;
  logic [1:0]        tgt_lvl;
  logic [6:0]        set_vec, clr_vec;
  logic [SYND_W-1:0] synd_nxt;

  always_comb begin
    case (cur_lvl)
      2'd3:    eff_mode = mode_l3;
      2'd2:    eff_mode = mode_l2;
      2'd1:    eff_mode = mode_l1;
      default: eff_mode = (host_en && trap_gen) ? mode_l0_host : mode_l0_guest;
    endcase
  end

  assign fire    = ev_valid && (eff_mode == MODE_FAULT);
  assign rec     = ev_valid && (eff_mode == MODE_RECORD);
  assign tgt_lvl = (cur_lvl == 2'd0) ? (trap_gen ? 2'd2 : 2'd1) : cur_lvl;
  assign clr_vec = clr_valid ? clr_mask : 7'd0;

  always_comb begin
    set_vec = '0;
    if (rec) begin
      if (cur_lvl == 2'd3) set_vec[6] = 1'b1;
      else                 set_vec[{cur_lvl, ev_addr[TAG_BIT]}] = 1'b1;
    end
  end

  always_comb begin
    synd_nxt      = '0;
    synd_nxt[5:0] = SYND_CODE;
    synd_nxt[6]   = ev_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_lvl   <= '0;
      flt_synd  <= '0;
      flt_addr  <= '0;
      tf_flags  <= '0;
    end else begin
      flt_valid <= fire;
      if (fire) begin
        flt_lvl  <= tgt_lvl;
        flt_synd <= synd_nxt;
        flt_addr <= ev_addr;
      end
      tf_flags <= (tf_flags & ~clr_vec) | set_vec;
    end
  end

  assign flt_vec_off = '0;

  a_r4_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flt_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !flt_valid);
  a_r7_record_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> !flt_valid);
  a_r5_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> flt_lvl != 2'd0);
  a_r6_synd_code: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> flt_synd[5:0] == SYND_CODE);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> (tf_flags & $past(tf_flags)) == $past(tf_flags));
  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && !clr_valid) |=> $countones(tf_flags ^ $past(tf_flags)) <= 1);
endmodule

// File: tb/sim_tag_fail_unit.sv
module sim_tag_fail_unit;
  localparam int ADDR_W = 64;
  localparam int SYND_W = 25;
  localparam int VEC_W  = 12;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_write = 0, host_en = 0, trap_gen = 0, clr_valid = 0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic [1:0] cur_lvl = 0, mode_l3 = 0, mode_l2 = 0, mode_l1 = 0, mode_l0_host = 0, mode_l0_guest = 0;
  logic [6:0] clr_mask = 0;
  logic flt_valid;
  logic [1:0] flt_lvl;
  logic [SYND_W-1:0] flt_synd;
  logic [ADDR_W-1:0] flt_addr;
  logic [VEC_W-1:0] flt_vec_off;
  logic [6:0] tf_flags;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tag_fail_unit u0 (.clk, .rst_n, .ev_valid, .ev_addr, .ev_write, .cur_lvl,
    .mode_l3, .mode_l2, .mode_l1, .mode_l0_host, .mode_l0_guest, .host_en,
    .trap_gen, .clr_valid, .clr_mask, .flt_valid, .flt_lvl, .flt_synd,
    .flt_addr, .flt_vec_off, .tf_flags);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr_valid = 1; clr_mask = 7'h7f;
    @(negedge clk); clr_valid = 0; clr_mask = 0;
  endtask

  task automatic fire_ev(input logic [1:0] lvl, input logic [ADDR_W-1:0] a, input logic w);
    @(negedge clk); ev_valid = 1; cur_lvl = lvl; ev_addr = a; ev_write = w;
    @(negedge clk); ev_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flt_valid", flt_valid, 0);
    chk("R1 flags", tf_flags, 0);
    rst_n = 1;

    for (int lvl = 0; lvl < 4; lvl++)
      for (int m = 0; m < 4; m++)
        for (int he = 0; he < 2; he++)
          for (int tg = 0; tg < 2; tg++)
            for (int w = 0; w < 2; w++)
              for (int b = 0; b < 2; b++) begin
                logic [1:0] other;
                logic [ADDR_W-1:0] a;
                logic [6:0] ef;
                logic [SYND_W-1:0] es;
                logic [1:0] et;
                other = ~m[1:0];
                mode_l3 = other; mode_l2 = other; mode_l1 = other;
                mode_l0_host = other; mode_l0_guest = other;
                host_en = he[0]; trap_gen = tg[0];
                case (lvl)
                  3: mode_l3 = m[1:0];
                  2: mode_l2 = m[1:0];
                  1: mode_l1 = m[1:0];
                  default: if (he == 1 && tg == 1) mode_l0_host = m[1:0]; else mode_l0_guest = m[1:0];
                endcase
                a = 64'h0123_4567_89AB_CDEF ^ (64'(lvl * 16 + m * 4 + he * 2 + tg) << 8);
                a[55] = b[0];
                fire_ev(lvl[1:0], a, w[0]);
                ef = 0;
                if (m == 2) begin
                  if (lvl == 3) ef[6] = 1; else ef[lvl * 2 + b] = 1;
                end
                chk(lvl == 0 ? "R3 flt_valid" : "R2 flt_valid", flt_valid, m == 1);
                chk(lvl == 3 ? "R8 flags" : (m == 2 ? "R7 flags" : "R9 flags"), tf_flags, ef);
                if (m == 1) begin
                  es = 0; es[5:0] = 6'b010001; es[6] = w[0];
                  et = (lvl == 0) ? (tg == 1 ? 2'd2 : 2'd1) : lvl[1:0];
                  chk("R5 target", flt_lvl, et);
                  chk("R6 syndrome", flt_synd, es);
                  chk("R6 vec_off", flt_vec_off, 0);
                  chk("R4 addr", flt_addr, a);
                  @(negedge clk);
                  chk("R4 one pulse", flt_valid, 0);
                end
                clear_all();
              end

    // R11: idle cycle with fault mode everywhere
    mode_l3 = 1; mode_l2 = 1; mode_l1 = 1; mode_l0_host = 1; mode_l0_guest = 1;
    @(negedge clk); ev_valid = 0;
    @(negedge clk);
    chk("R11 no fault", flt_valid, 0);
    chk("R11 flags", tf_flags, 0);

    // R10: sticky, masked clear, set beats clear
    mode_l2 = 2; mode_l1 = 2;
    fire_ev(2'd2, 64'h0080_0000_0000_0000, 0);
    fire_ev(2'd1, 64'h0, 0);
    chk("R10 two set", tf_flags, 7'b0100100);
    repeat (3) @(negedge clk);
    chk("R10 held", tf_flags, 7'b0100100);
    @(negedge clk); clr_valid = 1; clr_mask = 7'b0000100;
    @(negedge clk); clr_valid = 0; clr_mask = 0;
    chk("R10 masked clear", tf_flags, 7'b0100000);
    @(negedge clk); ev_valid = 1; cur_lvl = 1; ev_addr = 0; clr_valid = 1; clr_mask = 7'h7f;
    @(negedge clk); ev_valid = 0; clr_valid = 0; clr_mask = 0;
    chk("R10 set wins", tf_flags, 7'b0000100);
    @(negedge clk); clr_valid = 0; clr_mask = 7'h7f;
    @(negedge clk); clr_mask = 0;
    chk("R10 mask without strobe", tf_flags, 7'b0000100);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule